// File: doc/BRIEF.md
# Shareable Level-Triggered Interrupt Source

This block is the interrupt front end of a peripheral that shares one interrupt wire with other devices. Internal event pulses set bits in a pending-flag register. Each bit has an enable bit in a mask register. While at least one flag is both pending and enabled, the block pulls its request low through an active-low output enable. Otherwise it releases the line, so the board can wire-OR several such sources onto one wire.

Software reaches the block through a simple register port. It can read the pending flags, read and write the enable mask, and read a one-bit summary. It clears flags by writing ones to the pending register. Reads never change state and always complete one cycle after the request. A driver that polls every device on the shared line can therefore read status even when this device has nothing pending. The request holds as a steady level until software removes its cause, so an assertion by a neighbour on the same wire cannot mask it.

Register map (the 2-bit `addr`): 0 holds the pending flags (read; write 1 to clear). 1 holds the enable mask (read/write). 2 holds the summary (read; bit 0 = any enabled flag pending). 3 is reserved.

Top module: `shared_irq_source`

## Requirements
- R1: After reset all pending flags are 0, the enable mask is 0, and `irq_oe_n` is 1 (line released).
- R2: A 1 on bit k of `evt_i` for one cycle sets pending flag k. The flag reads as 1 at address 0 on any later read until it is cleared.
- R3: A read never alters the pending flags or the mask. Reading address 0 twice gives the same value, and `irq_oe_n` does not change.
- R4: Every read completes: `rvalid` is 1 exactly on the cycle after `rd_en` and 0 otherwise. A read of address 0 with nothing pending returns 0.
- R5: Writing to address 0 clears exactly the flags whose `wdata` bits are 1 and leaves the other flags unchanged.
- R6: If an event and a clear for the same bit land in the same cycle, the flag ends up set.
- R7: `irq_oe_n` is 0 exactly when the current pending flags ANDed with the current mask are non-zero. It follows a flag or mask change on the cycle after the edge that stored that change.
- R8: A flag whose enable bit is 0 is still recorded and readable at address 0, but it does not drive the request.
- R9: A write to address 1 stores `wdata` as the enable mask, and a read of address 1 returns it.
- R10: A read of address 2 returns bit 0 equal to the inverse of `irq_oe_n` in the read cycle, with all other bits 0.
- R11: While nothing is written, a request once driven stays driven, whatever other events arrive.
- R12: Reads of address 3 return 0, and writes to address 3 change neither the flags nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | Single-cycle event pulses, one per source |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | NUM_SRC | Write data |
| rdata | output | NUM_SRC | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq_oe_n | output | 1 | Active-low line drive enable for the shared request |

## Verification
The assertions assume that event pulses and host strobes are free of X once reset is released. They also assume the request only needs to persist across cycles with no write, because any write may legally clear a flag or change the mask. The stimulus changes every input on the falling clock edge and holds it for exactly one rising edge. Every requirement has its own directed scenario. Set-against-clear collisions are created on purpose, and every other case keeps writes apart from events.

// File: rtl/irq_src_pkg.sv
// Package: shared definitions for the shareable interrupt source.
// Assumes a fixed 2-bit register address space.
package irq_src_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_ANY  = 2'd2,
        REG_RSVD = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Holds one sticky pending flag per source. An event sets its flag and a
// clear bit resets it. When both arrive in the same cycle, the set wins.
// Assumes events are synchronous single-cycle pulses.
module irq_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // Per-source sticky flag with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[k] <= 1'b0;
            else if (set_i[k])
                flag_o[k] <= 1'b1;
            else if (clr_i[k])
                flag_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_host_port.sv
// Module: irq_host_port
// Decodes host writes into the mask register and flag-clear strobes.
// Returns registered read data with a fixed one-cycle latency.
// Reads have no side effects. Assumes rd_en and wr_en are single-cycle strobes.
module irq_host_port
    import irq_src_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      flag_i,
    input  logic              any_i,
    output logic [N-1:0]      clr_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      rdata,
    output logic              rvalid
);
    logic [N-1:0] rd_mux;

    // Write-one-to-clear strobes toward the flag bank.
    always_comb begin
        clr_o = '0;
        if (wr_en && (addr == REG_PEND))
            clr_o = wdata;
    end

    // Enable mask storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_en && (addr == REG_MASK))
            mask_o <= wdata;
    end

    // Read data selection; reserved space reads zero.
    always_comb begin
        rd_mux = '0;
        unique case (addr)
            REG_PEND: rd_mux = flag_i;
            REG_MASK: rd_mux = mask_o;
            REG_ANY:  rd_mux[0] = any_i;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read response, always one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_line_driver.sv
// Module: irq_line_driver
// Turns enabled pending flags into the active-low line enable and the summary
// bit. It is purely combinational, so both follow the stored state with the same timing.
// Assumes an external pull-up holds the shared line when released.
module irq_line_driver #(
    parameter int N = 8
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] mask_i,
    output logic         any_o,
    output logic         oe_n_o
);
    // Drive only for this block's own enabled events.
    always_comb begin
        any_o  = |(flag_i & mask_i);
        oe_n_o = ~any_o;
    end
endmodule

// File: rtl/shared_irq_source.sv
// Module: shared_irq_source (top)
// Level-sensitive interrupt source that can share one wired-OR line.
// It has a pending flag bank, a host register port and a line driver.
// Assumes evt_i is synchronous to clk and the reset is synchronous active-low.
module shared_irq_source
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    output logic               rvalid,
    output logic               irq_oe_n
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr_w;
    logic               any_w;

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .clr_i  (clr_w),
        .flag_o (pend_q)
    );

    irq_host_port #(.N(NUM_SRC)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .flag_i (pend_q),
        .any_i  (any_w),
        .clr_o  (clr_w),
        .mask_o (mask_q),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    irq_line_driver #(.N(NUM_SRC)) u_drv (
        .flag_i (pend_q),
        .mask_i (mask_q),
        .any_o  (any_w),
        .oe_n_o (irq_oe_n)
    );
endmodule

// File: rtl/irq_source_chk.sv
// Module: irq_source_chk
// Property checker bound to shared_irq_source. It observes the ports plus
// the stored flag and mask state.
module irq_source_chk
    import irq_src_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      evt_i,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      rdata,
    input logic              rvalid,
    input logic              irq_oe_n,
    input logic [N-1:0]      pend_q,
    input logic [N-1:0]      mask_q
);
    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);                                               // R4
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);                                             // R4
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_PEND && pend_q == '0) |=> (rdata == '0));  // R4
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));    // R6
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && evt_i == '0) |=> $stable(pend_q) && $stable(mask_q)); // R3
    AST_REQ_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe_n |-> ((pend_q & mask_q) != '0));                        // R7
    AST_REQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_oe_n && !wr_en) |=> !irq_oe_n);                            // R11
    AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_ANY) |=> (rdata[0] == !$past(irq_oe_n)));  // R10
endmodule

bind shared_irq_source irq_source_chk #(.N(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .irq_oe_n (irq_oe_n),
    .pend_q   (pend_q),
    .mask_q   (mask_q)
);

// File: tb/tb_shared_irq_source.sv
// Directed bench for shared_irq_source: one task per scenario.
module tb_shared_irq_source;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         rvalid;
    logic         irq_oe_n;

    int checks = 0;
    int errors = 0;

    shared_irq_source #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq_oe_n(irq_oe_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One idle cycle; the caller samples at the falling edge afterwards.
    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [N-1:0] v);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d, output logic v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rvalid;
    endtask

    task automatic t_reset();
        logic [N-1:0] d; logic v;
        check("R1 line released", 32'(irq_oe_n), 32'd1);
        rd(2'd0, d, v); check("R1 flags zero", 32'(d), 32'd0);
        rd(2'd1, d, v); check("R1 mask zero", 32'(d), 32'd0);
    endtask

    task automatic t_idle_read();
        logic [N-1:0] d; logic v;
        rd(2'd0, d, v);
        check("R4 rvalid after read", 32'(v), 32'd1);
        check("R4 empty read zero", 32'(d), 32'd0);
        idle();
        check("R4 rvalid low when idle", 32'(rvalid), 32'd0);
    endtask

    task automatic t_event_set();
        logic [N-1:0] d; logic v;
        pulse(8'h05);
        idle();
        rd(2'd0, d, v); check("R2 flags set", 32'(d), 32'h05);
        check("R8 masked flag no request", 32'(irq_oe_n), 32'd1);
    endtask

    task automatic t_mask();
        logic [N-1:0] d; logic v;
        wr(2'd1, 8'h04);
        rd(2'd1, d, v); check("R9 mask readback", 32'(d), 32'h04);
        check("R7 request on enabled flag", 32'(irq_oe_n), 32'd0);
    endtask

    task automatic t_read_no_side();
        logic [N-1:0] d1, d2; logic v;
        rd(2'd0, d1, v);
        rd(2'd0, d2, v);
        check("R3 repeated read equal", 32'(d2), 32'(d1));
        check("R3 request unchanged", 32'(irq_oe_n), 32'd0);
    endtask

    task automatic t_summary();
        logic [N-1:0] d; logic v;
        rd(2'd2, d, v); check("R10 summary set", 32'(d), 32'h01);
    endtask

    task automatic t_level_hold();
        pulse(8'h80);
        idle(); idle();
        check("R11 request held", 32'(irq_oe_n), 32'd0);
    endtask

    task automatic t_unused();
        logic [N-1:0] d; logic v;
        wr(2'd3, 8'hFF);
        rd(2'd3, d, v); check("R12 reserved reads zero", 32'(d), 32'd0);
        rd(2'd0, d, v); check("R12 flags untouched", 32'(d), 32'h85);
        rd(2'd1, d, v); check("R12 mask untouched", 32'(d), 32'h04);
    endtask

    task automatic t_w1c();
        logic [N-1:0] d; logic v;
        wr(2'd0, 8'h04);
        rd(2'd0, d, v); check("R5 only bit2 cleared", 32'(d), 32'h81);
        check("R7 request released", 32'(irq_oe_n), 32'd1);
        rd(2'd2, d, v); check("R10 summary clear", 32'(d), 32'h00);
    endtask

    task automatic t_set_wins();
        logic [N-1:0] d; logic v;
        evt_i = 8'h02; wr_en = 1'b1; addr = 2'd0; wdata = 8'h83;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; wdata = '0;
        rd(2'd0, d, v); check("R6 set beats clear", 32'(d), 32'h02);
        wr(2'd1, 8'h02);
        check("R7 request after mask write", 32'(irq_oe_n), 32'd0);
        wr(2'd0, 8'h02);
        check("R7 released after clear", 32'(irq_oe_n), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_event_set();
        t_mask();
        t_read_no_side();
        t_summary();
        t_level_hold();
        t_unused();
        t_w1c();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule